// File: doc/BRIEF.md
# Interleaved SDRAM Write Stream Sequencer

This block drives the command bus of an SDRAM so that a long sequential write stream keeps the data bus busy on every cycle. It writes one row in bursts, one WRITE every half burst length in command cycles. While the last bursts of a row are still going out, it opens the same row address in the following bank. It then closes the bank it has just left in a spare slot. The bank index runs upward. When it passes the last bank it returns to zero and the row advances. The stream ends after the last row of the last bank.

A refresh arbiter can halt the stream with a request line. The sequencer lets the current burst finish and closes the open bank. It then raises an acknowledge and issues only idle commands until the request is dropped. After that it reopens the saved bank and row and continues from the next column. Data movement, strobe timing, reads and the refresh commands themselves are handled elsewhere.

Top module: `wrseq_top`

## Requirements
- R1: In reset and in the first cycle after reset, the command output is NOP, `seqDone` is 0 and `pauseAck` is 0. The command codes are NOP=0, ACTIVE=1, WRITE=2, PRECHARGE=3.
- R2: A `startPulse` sampled while idle produces ACTIVE in the next cycle, on `startBank`/`startRow`. The first WRITE, to column 0 of that bank and row, follows T_RCD (3) cycles after that ACTIVE.
- R3: Within one row, WRITEs come every BURST_LEN/2 (4) cycles. The column rises by BURST_LEN (8) per WRITE, from 0 up to 2^COL_W - BURST_LEN.
- R4: In the cycle right after the second-to-last WRITE of a row, ACTIVE is issued on the next bank. The next bank is bank+1 with the same row. After the highest bank it is bank 0 with row+1. The final bank of the final row opens no next bank.
- R5: The first WRITE to the newly opened bank comes exactly BURST_LEN/2 cycles after the last WRITE to the old bank.
- R6: In the cycle right after the first WRITE to the new bank, PRECHARGE is issued on the old bank.
- R7: Every cycle that carries none of the commands above carries NOP.
- R8: After the last WRITE to the highest bank of row NUM_ROWS-1, PRECHARGE of that bank follows in the next cycle. `seqDone` rises in the same cycle. `seqDone` stays 1, with NOP on the bus, until the next start clears it.
- R9: A pause is taken only at a WRITE whose burst index lies in 1..BURSTS-3 while `pauseReq` is high. In the next cycle, PRECHARGE of the current bank is issued and `pauseAck` rises with it. A request seen at burst 0 waits for burst 1.
- R10: While `pauseAck` is high, the command output is NOP.
- R11: The cycle after `pauseReq` is seen low while paused, `pauseAck` falls and ACTIVE reopens the saved bank and row. T_RCD cycles later, WRITE resumes at the column after the last one written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begin a stream (honoured only while idle) |
| startBank | input | BANK_W | First bank of the stream |
| startRow | input | ROW_W | First row of the stream |
| pauseReq | input | 1 | Halt request from the refresh arbiter |
| cmdOut | output | 2 | Command code for this cycle |
| cmdBank | output | BANK_W | Bank field |
| cmdRow | output | ROW_W | Row field |
| cmdCol | output | COL_W | Column field |
| pauseAck | output | 1 | All banks closed, stream held |
| seqDone | output | 1 | Stream finished (sticky until next start) |

## Verification
The bench builds the block with two banks, three rows and a 5-bit column, so each row takes only four bursts. This brings several events within a few dozen cycles: bank-to-bank handover, the bank wrap with row increment, and the final close with `seqDone`. With four bursts per row, only burst 1 can accept a pause. A request held from the start therefore shows both the deferral at burst 0 and acceptance at the first legal slot. The stream then resumes straight into a handover.

// File: rtl/wrseq_pkg.sv
package wrseq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } sdCmd_e;

  // control -> datapath
  typedef struct packed {
    logic loadStart;
    logic actCur;
    logic actNext;
    logic wr;
    logic preOld;
    logic preCur;
  } seqStrobe_t;

  // datapath -> control, describing the burst about to be written
  typedef struct packed {
    logic burstFirst;
    logic burstPenult;
    logic burstLast;
    logic finalGroup;
    logic pauseOk;
  } seqFlags_t;

endpackage

// File: rtl/wrseq_datapath.sv
module wrseq_datapath
  import wrseq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8192,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 8,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  input  logic [BANK_W-1:0] startBank,
  input  logic [ROW_W-1:0]  startRow,
  output seqFlags_t         flags,
  output sdCmd_e            cmdOut,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol
);

  localparam int BURSTS = (1 << COL_W) / BURST_LEN;
  localparam int BIDX_W = $clog2(BURSTS);
  localparam int LOG_BL = $clog2(BURST_LEN);

  logic [BANK_W-1:0] curBank, prevBank, nxtBank;
  logic [ROW_W-1:0]  curRow, prevRow, nxtRow;
  logic [BIDX_W-1:0] burstIdx;
  logic              bankWrap;

  generate
    if ((1 << BANK_W) == NUM_BANKS) begin : g_wrapPow2
      assign bankWrap = &curBank;
    end else begin : g_wrapCmp
      assign bankWrap = (curBank == BANK_W'(NUM_BANKS - 1));
    end
  endgenerate

  assign nxtBank = bankWrap ? '0 : curBank + BANK_W'(1);
  assign nxtRow  = bankWrap ? curRow + ROW_W'(1) : curRow;

  assign flags.burstFirst  = (burstIdx == '0);
  assign flags.burstPenult = (burstIdx == BIDX_W'(BURSTS - 2));
  assign flags.burstLast   = (burstIdx == BIDX_W'(BURSTS - 1));
  assign flags.finalGroup  = bankWrap && (curRow == ROW_W'(NUM_ROWS - 1));
  assign flags.pauseOk     = (burstIdx != '0) && (burstIdx < BIDX_W'(BURSTS - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curBank  <= '0;
      curRow   <= '0;
      prevBank <= '0;
      prevRow  <= '0;
      burstIdx <= '0;
      cmdOut   <= CMD_NOP;
      cmdBank  <= '0;
      cmdRow   <= '0;
      cmdCol   <= '0;
    end else begin
      cmdOut <= CMD_NOP;
      if (strb.loadStart) begin
        curBank  <= startBank;
        curRow   <= startRow;
        burstIdx <= '0;
        cmdOut   <= CMD_ACT;
        cmdBank  <= startBank;
        cmdRow   <= startRow;
        cmdCol   <= '0;
      end
      if (strb.actCur) begin
        cmdOut  <= CMD_ACT;
        cmdBank <= curBank;
        cmdRow  <= curRow;
      end
      if (strb.actNext) begin
        cmdOut  <= CMD_ACT;
        cmdBank <= nxtBank;
        cmdRow  <= nxtRow;
      end
      if (strb.wr) begin
        cmdOut  <= CMD_WR;
        cmdBank <= curBank;
        cmdRow  <= curRow;
        cmdCol  <= {burstIdx, {LOG_BL{1'b0}}};
        if (flags.burstLast) begin
          prevBank <= curBank;
          prevRow  <= curRow;
          curBank  <= nxtBank;
          curRow   <= nxtRow;
          burstIdx <= '0;
        end else begin
          burstIdx <= burstIdx + BIDX_W'(1);
        end
      end
      if (strb.preOld) begin
        cmdOut  <= CMD_PRE;
        cmdBank <= prevBank;
        cmdRow  <= prevRow;
      end
      if (strb.preCur) begin
        cmdOut  <= CMD_PRE;
        cmdBank <= curBank;
        cmdRow  <= curRow;
      end
    end
  end

  // R3: two WRITEs never sit in adjacent cycles
  assert_write_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOut == CMD_WR) |=> (cmdOut != CMD_WR));

  // R2: an ACTIVE is always followed by an idle slot
  assert_act_then_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOut == CMD_ACT) |=> (cmdOut == CMD_NOP));

endmodule

// File: rtl/wrseq_ctrl.sv
module wrseq_ctrl
  import wrseq_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int SLOT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startPulse,
  input  logic       pauseReq,
  input  seqFlags_t  flags,
  output seqStrobe_t strb,
  output logic       pauseAck,
  output logic       seqDone
);

  localparam int MAX_WAIT = (T_RCD > SLOT) ? T_RCD : SLOT;
  localparam int WAIT_W   = $clog2(MAX_WAIT);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PAUSED} seqState_e;
  typedef enum logic [2:0] {P_NONE, P_ACT_NEXT, P_PRE_PREV, P_PRE_PAUSE, P_PRE_DONE} postAct_e;

  seqState_e         st, stN;
  postAct_e          post, postN;
  logic [WAIT_W-1:0] waitCnt, waitN;
  logic              pendPre, pendN;
  logic              doneQ, doneN;

  always_comb begin
    strb  = '0;
    stN   = st;
    postN = post;
    waitN = waitCnt;
    pendN = pendPre;
    doneN = doneQ;
    case (st)
      ST_IDLE: begin
        if (startPulse) begin
          strb.loadStart = 1'b1;
          stN   = ST_RUN;
          waitN = WAIT_W'(T_RCD - 1);
          postN = P_NONE;
          pendN = 1'b0;
          doneN = 1'b0;
        end
      end
      ST_RUN: begin
        if (waitCnt != '0) waitN = waitCnt - WAIT_W'(1);
        case (post)
          P_ACT_NEXT:  strb.actNext = 1'b1;
          P_PRE_PREV:  strb.preOld  = 1'b1;
          P_PRE_PAUSE: begin
            strb.preCur = 1'b1;
            stN = ST_PAUSED;
          end
          P_PRE_DONE: begin
            strb.preOld = 1'b1;
            stN   = ST_IDLE;
            doneN = 1'b1;
          end
          default: ;
        endcase
        if (post != P_NONE) postN = P_NONE;
        if (waitCnt == '0) begin
          strb.wr = 1'b1;
          waitN   = WAIT_W'(SLOT - 1);
          if (flags.burstLast && flags.finalGroup) begin
            postN = P_PRE_DONE;
          end else if (flags.burstPenult && !flags.finalGroup) begin
            postN = P_ACT_NEXT;
          end else if (flags.burstFirst && pendPre) begin
            postN = P_PRE_PREV;
            pendN = 1'b0;
          end else if (pauseReq && flags.pauseOk) begin
            postN = P_PRE_PAUSE;
          end
          if (flags.burstLast && !flags.finalGroup) pendN = 1'b1;
        end
      end
      ST_PAUSED: begin
        if (!pauseReq) begin
          strb.actCur = 1'b1;
          stN   = ST_RUN;
          waitN = WAIT_W'(T_RCD - 1);
        end
      end
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      post    <= P_NONE;
      waitCnt <= '0;
      pendPre <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      st      <= stN;
      post    <= postN;
      waitCnt <= waitN;
      pendPre <= pendN;
      doneQ   <= doneN;
    end
  end

  assign pauseAck = (st == ST_PAUSED);
  assign seqDone  = doneQ;

  // R9: acknowledge only rises when a request stood at the accepting WRITE
  assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pauseAck) |-> $past(pauseReq, 2));

  // R11: a dropped request releases the pause on the next cycle
  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pauseAck && !pauseReq) |=> !pauseAck);

endmodule

// File: rtl/wrseq_top.sv
module wrseq_top
  import wrseq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8192,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic [BANK_W-1:0] startBank,
  input  logic [ROW_W-1:0]  startRow,
  input  logic              pauseReq,
  output logic [1:0]        cmdOut,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              pauseAck,
  output logic              seqDone
);

  localparam int SLOT = BURST_LEN / 2;

  seqStrobe_t strb;
  seqFlags_t  flags;
  sdCmd_e     cmdE;

  wrseq_ctrl #(
    .T_RCD (T_RCD),
    .SLOT  (SLOT)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .pauseReq   (pauseReq),
    .flags      (flags),
    .strb       (strb),
    .pauseAck   (pauseAck),
    .seqDone    (seqDone)
  );

  wrseq_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_ROWS  (NUM_ROWS),
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN),
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .startBank (startBank),
    .startRow  (startRow),
    .flags     (flags),
    .cmdOut    (cmdE),
    .cmdBank   (cmdBank),
    .cmdRow    (cmdRow),
    .cmdCol    (cmdCol)
  );

  assign cmdOut = cmdE;

  // R10: bus stays idle while held
  assert_quiet_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pauseAck && $past(pauseAck)) |-> (cmdOut == 2'd0));

  // R9: acknowledge arrives together with the closing PRECHARGE
  assert_pre_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pauseAck) |-> (cmdOut == 2'd3));

  // R8: completion coincides with the final PRECHARGE
  assert_pre_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seqDone) |-> (cmdOut == 2'd3));

endmodule

// File: tb/wrseq_tb.sv
`timescale 1ns/1ps
module wrseq_top_tb_top;

  localparam int NB = 2;
  localparam int NR = 3;
  localparam int CW = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startPulse = 1'b0;
  logic [0:0] startBank = '0;
  logic [1:0] startRow = '0;
  logic       pauseReq = 1'b0;
  logic [1:0] cmdOut;
  logic [0:0] cmdBank;
  logic [1:0] cmdRow;
  logic [4:0] cmdCol;
  logic       pauseAck;
  logic       seqDone;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wrseq_top #(
    .NUM_BANKS (NB),
    .NUM_ROWS  (NR),
    .COL_W     (CW),
    .BURST_LEN (8),
    .T_RCD     (3)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .startBank  (startBank),
    .startRow   (startRow),
    .pauseReq   (pauseReq),
    .cmdOut     (cmdOut),
    .cmdBank    (cmdBank),
    .cmdRow     (cmdRow),
    .cmdCol     (cmdCol),
    .pauseAck   (pauseAck),
    .seqDone    (seqDone)
  );

  // {cycle[7:0], cmd[1:0], bank, row[1:0], col[4:0]}
  localparam int NEV = 18;
  localparam logic [17:0] EXP [NEV] = '{
    {8'd0,  2'd1, 1'd1, 2'd1, 5'd0},
    {8'd3,  2'd2, 1'd1, 2'd1, 5'd0},
    {8'd7,  2'd2, 1'd1, 2'd1, 5'd8},
    {8'd11, 2'd2, 1'd1, 2'd1, 5'd16},
    {8'd12, 2'd1, 1'd0, 2'd2, 5'd0},
    {8'd15, 2'd2, 1'd1, 2'd1, 5'd24},
    {8'd19, 2'd2, 1'd0, 2'd2, 5'd0},
    {8'd20, 2'd3, 1'd1, 2'd1, 5'd0},
    {8'd23, 2'd2, 1'd0, 2'd2, 5'd8},
    {8'd27, 2'd2, 1'd0, 2'd2, 5'd16},
    {8'd28, 2'd1, 1'd1, 2'd2, 5'd0},
    {8'd31, 2'd2, 1'd0, 2'd2, 5'd24},
    {8'd35, 2'd2, 1'd1, 2'd2, 5'd0},
    {8'd36, 2'd3, 1'd0, 2'd2, 5'd0},
    {8'd39, 2'd2, 1'd1, 2'd2, 5'd8},
    {8'd43, 2'd2, 1'd1, 2'd2, 5'd16},
    {8'd47, 2'd2, 1'd1, 2'd2, 5'd24},
    {8'd48, 2'd3, 1'd1, 2'd2, 5'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input int t, input int cmd);
    if (cmd == 1) return (t == 0) ? "R2 act" : "R4 act";
    if (cmd == 3) return (t == 48) ? "R8 pre" : "R6 pre";
    if (cmd == 2) begin
      if (t == 3) return "R2 wr";
      if (t == 19 || t == 35) return "R5 wr";
      return "R3 wr";
    end
    return "R7 nop";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int doneAt;
    repeat (3) @(negedge clk);
    chk("R1 cmd in reset", int'(cmdOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd", int'(cmdOut), 0);
    chk("R1 done", int'(seqDone), 0);
    chk("R1 ack", int'(pauseAck), 0);

    // ---- table-driven full stream: bank 1 row 1 to the end ----
    startBank = 1'b1; startRow = 2'd1; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int t = 0; t <= 52; t++) begin
      bit hit = 1'b0;
      for (int e = 0; e < NEV; e++) begin
        if (int'(EXP[e][17:10]) == t) begin
          hit = 1'b1;
          chk(tagFor(t, int'(EXP[e][9:8])), int'(cmdOut), int'(EXP[e][9:8]));
          chk(tagFor(t, int'(EXP[e][9:8])), int'(cmdBank), int'(EXP[e][7]));
          if (EXP[e][9:8] != 2'd3)
            chk(tagFor(t, int'(EXP[e][9:8])), int'(cmdRow), int'(EXP[e][6:5]));
          if (EXP[e][9:8] == 2'd2)
            chk(tagFor(t, 2), int'(cmdCol), int'(EXP[e][4:0]));
        end
      end
      if (!hit) chk("R7 nop", int'(cmdOut), 0);
      if (t == 47) chk("R8 done before final close", int'(seqDone), 0);
      if (t == 48) chk("R8 done with final close", int'(seqDone), 1);
      if (t == 52) chk("R8 done sticky", int'(seqDone), 1);
      @(negedge clk);
    end

    // ---- pause held from the start: deferral, acceptance, resume ----
    startBank = 1'b0; startRow = 2'd0; startPulse = 1'b1; pauseReq = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R8 restart clears done", int'(seqDone), 0);
    for (int t = 0; t <= 19; t++) begin
      if (t == 3) begin
        chk("R9 burst0 not paused", int'(cmdOut), 2);
        chk("R9 no ack at burst0", int'(pauseAck), 0);
      end
      if (t == 7) chk("R9 burst1 written", int'(cmdCol), 8);
      if (t == 8) begin
        chk("R9 pre on pause", int'(cmdOut), 3);
        chk("R9 pre bank", int'(cmdBank), 0);
        chk("R9 ack rises", int'(pauseAck), 1);
      end
      if (t >= 9 && t <= 14) begin
        chk("R10 nop while paused", int'(cmdOut), 0);
        chk("R10 ack held", int'(pauseAck), 1);
      end
      if (t == 14) pauseReq = 1'b0;
      if (t == 15) begin
        chk("R11 reactivate", int'(cmdOut), 1);
        chk("R11 bank", int'(cmdBank), 0);
        chk("R11 row", int'(cmdRow), 0);
        chk("R11 ack falls", int'(pauseAck), 0);
      end
      if (t == 16 || t == 17) chk("R11 spacing nop", int'(cmdOut), 0);
      if (t == 18) begin
        chk("R11 resume write", int'(cmdOut), 2);
        chk("R11 resume column", int'(cmdCol), 16);
      end
      if (t == 19) begin
        chk("R4 next act", int'(cmdOut), 1);
        chk("R4 next bank", int'(cmdBank), 1);
      end
      @(negedge clk);
    end
    doneAt = -1;
    for (int t = 20; t <= 200; t++) begin
      if (seqDone && doneAt < 0) begin
        doneAt = t;
        chk("R8 final pre", int'(cmdOut), 3);
        chk("R8 final bank", int'(cmdBank), 1);
      end
      if (doneAt < 0) @(negedge clk);
    end
    chk("R8 done cycle after pause", doneAt, 103);

    // ---- restart after completion ----
    startBank = 1'b1; startRow = 2'd0; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R2 restart act", int'(cmdOut), 1);
    chk("R2 restart bank", int'(cmdBank), 1);
    chk("R8 done cleared", int'(seqDone), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule